// File: doc/BRIEF.md
# Dual-Port Concurrent March Stimulus Generator

This block drives the test pattern for a small dual-port RAM. The RAM has a synchronous write port and an asynchronous read port, each with its own address. After a start pulse the generator runs a four-element march algorithm and issues one write and one read per clock cycle. In the last two elements the write address and the read address move through the array in opposite directions at the same time. Next to each read it gives the value the read should return, and a strobe that marks the reads a response analyzer should compare.

Every data word is all-zeros or all-ones; no background data patterns are used. The stimulus takes 4 x 2^AW cycles, which is 128 cycles for the default 32-word array. A one-cycle completion pulse follows the last operation.

Top module: `dp_march_gen`

## Requirements
- R1: While reset is held, and in idle, `busy`, `we`, `cmp_valid` and `done` are all 0. Reset is synchronous and active high.
- R2: Element A (the first 32 cycles after start is sampled) writes all-zeros at ascending addresses 0..31 with `we`=1 and `cmp_valid`=0.
- R3: Element B (the next 32 cycles) has `we`=0 and reads descending addresses 31..0 with `cmp_valid`=1 and `exp_data` all-zeros.
- R4: Element C (the next 32 cycles) writes all-ones at ascending addresses 0..31 and, in the same cycles, reads descending addresses 31..0.
- R5: In element C, `cmp_valid` is 1 exactly when the read address is below the write address (already rewritten in an earlier cycle), and then `exp_data` is all-ones.
- R6: Element D (the last 32 cycles) writes all-zeros at descending addresses 31..0 and, in the same cycles, reads ascending addresses 0..31.
- R7: In element D, `cmp_valid` is 1 exactly when the read address is above the write address, and then `exp_data` is all-zeros.
- R8: `done` is high for exactly one cycle, in the cycle right after the last element-D operation, and `busy` is 0 in that cycle.
- R9: `start` has no effect while `busy` is 1. The running sequence goes on unchanged.
- R10: Reset in the middle of a run returns the block to idle at once, and a later start begins again from element A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| waddr | output | AW | Write-port address |
| wdata | output | DW | Write-port data |
| we | output | 1 | Write enable |
| raddr | output | AW | Read-port address |
| exp_data | output | DW | Expected read data |
| cmp_valid | output | 1 | Read result is to be compared |

## Verification
The assertions assume that reset is applied at power-up and that `start` is a level sampled on rising edges. They assume nothing about how long `start` stays high. The bench drives only `start` and `rst`, and changes them on falling edges. In some runs it holds `start` high for many cycles in the middle of a run, and in one run it pulses reset at an arbitrary point. A behavioural RAM model in the bench takes the writes, and every flagged read is checked against what that model holds.

// File: rtl/dp_march_gen.sv
module dp_march_gen #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] exp_data,
  output logic          cmp_valid
);
  localparam logic [AW-1:0] TOP = '1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_SCAN, S_UP1, S_DN0} st_t;
  st_t st;
  logic [AW-1:0] wa, ra;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      wa   <= '0;
      ra   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_FILL;
          wa <= '0;
        end
        S_FILL: begin
          wa <= wa + 1'b1;
          if (wa == TOP) begin
            st <= S_SCAN;
            ra <= TOP;
          end
        end
        S_SCAN: begin
          ra <= ra - 1'b1;
          if (ra == '0) begin
            st <= S_UP1;
            wa <= '0;
            ra <= TOP;
          end
        end
        S_UP1: begin
          wa <= wa + 1'b1;
          ra <= ra - 1'b1;
          if (wa == TOP) begin
            st <= S_DN0;
            wa <= TOP;
            ra <= '0;
          end
        end
        S_DN0: begin
          wa <= wa - 1'b1;
          ra <= ra + 1'b1;
          if (wa == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign waddr     = wa;
  assign raddr     = ra;
  assign we        = (st == S_FILL) || (st == S_UP1) || (st == S_DN0);
  assign wdata     = (st == S_UP1) ? {DW{1'b1}} : '0;
  assign exp_data  = (st == S_UP1) ? {DW{1'b1}} : '0;
  assign cmp_valid = (st == S_SCAN) ||
                     ((st == S_UP1) && (ra < wa)) ||
                     ((st == S_DN0) && (ra > wa));
endmodule

module dp_march_gen_chk #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] waddr,
  input logic [DW-1:0] wdata,
  input logic          we,
  input logic [AW-1:0] raddr,
  input logic [DW-1:0] exp_data,
  input logic          cmp_valid
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!we && !cmp_valid));

  assert_read_only_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !we) |-> (cmp_valid && exp_data == '0));

  assert_ones_compare_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && we && wdata == {DW{1'b1}}) |-> (cmp_valid == (raddr < waddr)));

  assert_concurrent_match_R5: assert property (@(posedge clk) disable iff (rst)
    (we && cmp_valid) |-> (exp_data == wdata));

  assert_zero_compare_R7: assert property (@(posedge clk) disable iff (rst)
    (we && cmp_valid && wdata == '0) |-> (raddr > waddr));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind dp_march_gen dp_march_gen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .waddr(waddr),
  .wdata(wdata), .we(we), .raddr(raddr), .exp_data(exp_data),
  .cmp_valid(cmp_valid)
);

// File: tb/dp_march_gen_bench.sv
module dp_march_gen_bench;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, we, cmp_valid;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, exp_data;
  logic [DW-1:0] mem [N];
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dp_march_gen #(.AW(AW), .DW(DW)) u_dp_march_gen (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .waddr(waddr), .wdata(wdata), .we(we), .raddr(raddr),
    .exp_data(exp_data), .cmp_valid(cmp_valid)
  );

  always @(posedge clk) if (we) mem[waddr] <= wdata;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " busy"}, busy, 0);
    chk({req, " we"}, we, 0);
    chk({req, " cmp_valid"}, cmp_valid, 0);
  endtask

  task automatic chk_op(input int c);
    int e = c / N;
    int k = c % N;
    int ones = (1 << DW) - 1;
    chk("R9 busy during run", busy, 1);
    chk("R8 no early done", done, 0);
    case (e)
      0: begin
        chk("R2 we", we, 1); chk("R2 waddr", waddr, k);
        chk("R2 wdata", wdata, 0); chk("R2 cmp_valid", cmp_valid, 0);
      end
      1: begin
        chk("R3 we", we, 0); chk("R3 raddr", raddr, N-1-k);
        chk("R3 cmp_valid", cmp_valid, 1); chk("R3 exp_data", exp_data, 0);
      end
      2: begin
        chk("R4 we", we, 1); chk("R4 waddr", waddr, k);
        chk("R4 wdata", wdata, ones); chk("R4 raddr", raddr, N-1-k);
        chk("R5 cmp_valid", cmp_valid, (k >= N/2) ? 1 : 0);
        if (k >= N/2) chk("R5 exp_data", exp_data, ones);
      end
      default: begin
        chk("R6 we", we, 1); chk("R6 waddr", waddr, N-1-k);
        chk("R6 wdata", wdata, 0); chk("R6 raddr", raddr, k);
        chk("R7 cmp_valid", cmp_valid, (k >= N/2) ? 1 : 0);
        if (k >= N/2) chk("R7 exp_data", exp_data, 0);
      end
    endcase
    if (cmp_valid) chk("R5 R7 ram content", mem[raddr], exp_data);
  endtask

  task automatic run(input int hold_lo, input int hold_hi, input int abort_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 4*N; c++) begin
      if (c == abort_at) begin
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk_idle("R10 after abort");
        chk("R10 done", done, 0);
        @(negedge clk);
        chk_idle("R10 stays idle");
        return;
      end
      chk_op(c);
      start = (c >= hold_lo && c <= hold_hi);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8 done pulse", done, 1);
    chk("R8 busy low", busy, 0);
    @(negedge clk);
    chk("R8 done single", done, 0);
    chk_idle("R8 idle after run");
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 4'h5;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 idle");
    run(-1, -1, -1);
    repeat (2) @(negedge clk);
    run(5, 4*N-3, -1);
    run(-1, -1, 50);
    run(-1, -1, 100);
    run(-1, -1, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule